// File: doc/BRIEF.md
# Two-Stage Set-Associative Level-1 Data Cache

This block is a two-way set-associative data cache. A load or store goes through it in two pipeline stages. In the first stage, the set and word bits of the address start a read of the tag store and a read of the data store in the same cycle. The data read never waits for a tag comparison.

In the second stage, the registered tags are compared with the request tag. The matching way picks which of the two data words comes back. A store writes only in this stage, and only into the way that hit, under its byte enables.

The cache is write-back with write-allocate. On a miss it raises `stall` and picks a victim way. If the victim line is dirty, it writes that line to memory word by word. It then issues one line read, takes the refill words as they arrive, and replays the held access so that it completes as a hit. The requester keeps its request steady while `stall` is high. Memory is a simple request/response port that always accepts requests.

Top module: `dc_two_stage`

## Requirements
- R1: After a synchronous active-low reset, `stall`, `rsp_valid` and `mem_req_valid` are low, and every line is invalid.
- R2: Addresses are word aligned. Bits [3:2] select the word, bits [9:4] the set, and bits [31:10] form the tag. A load that hits raises `rsp_valid` with the word on `rsp_rdata` in the cycle after it is accepted, with no stall.
- R3: Hits are accepted in consecutive cycles without a stall. A load issued right after a store to the same word returns the stored bytes.
- R4: A store changes only the bytes whose enable bit is set: `req_be[i]` covers bits 8i+7..8i.
- R5: A missing access holds `stall` high until its replay completes. It issues exactly one line read, with the word and byte offset bits zero, and then returns the memory contents.
- R6: A store miss fetches the line and then merges the store into it. Stores write the data store only after a tag hit.
- R7: When the victim line is dirty, the cache writes its four words to memory at the victim's addresses, in increasing word order, before the line read. A clean victim causes no memory write. A refilled line is clean.
- R8: The victim is the first invalid way (way 0 before way 1). If both ways are valid, the victim is the least recently accessed way. A line is held in at most one way.
- R9: A store hit does not write memory.
- R10: Each accepted access produces exactly one `rsp_valid` pulse, in issue order, and never while `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Word-aligned byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| stall | output | 1 | Request not taken this cycle; hold it |
| rsp_valid | output | 1 | Access completed in stage two |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid |
| mem_req_valid | output | 1 | Memory request (always accepted) |
| mem_req_write | output | 1 | 1 = write-back word, 0 = line read |
| mem_req_addr | output | 32 | Word address or line base address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_rdata | input | 32 | Refill word, in increasing word order |

## Verification
The bench first uses cold loads, then hit loads and a store followed at once by a load. Together these separate the refill path from the stage-two hit path, and catch a missing forward of a store into the next read. Stores with sparse byte enables show whether the enables are honoured.

In one set, a sequence of misses evicts in turn an invalid way, a dirty way and a clean way. This tells apart the victim choice and the write-back against the refill ordering. A long pseudo-random mix of tags and sets, loads and stores then checks that ordering and data hold under replacement pressure.

// File: rtl/dc_pkg.sv
// Shared geometry and state encoding for the two-stage data cache.
// Assumes power-of-two sizes and exactly two ways (one LRU bit per set).
package dc_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int SETS       = 64;
    localparam int WAYS       = 2;
    localparam int LINE_BYTES = 16;
    localparam int BYTES_PW   = DATA_W / 8;
    localparam int WPL        = LINE_BYTES / BYTES_PW;
    localparam int BYTE_OFS   = $clog2(BYTES_PW);
    localparam int WORD_OFS   = $clog2(WPL);
    localparam int SET_W      = $clog2(SETS);
    localparam int WAY_W      = $clog2(WAYS);
    localparam int TAG_W      = ADDR_W - SET_W - WORD_OFS - BYTE_OFS;

    typedef enum logic [2:0] {
        MS_IDLE, MS_WBACK, MS_REQ, MS_FILL, MS_REPLAY
    } miss_state_t;
endpackage

// File: rtl/dc_data_store.sv
// Data store: one word array per way, indexed by set and word only.
// Registered read for stage one with forwarding of a same-cycle write;
// combinational read port for victim write-back; byte-enabled write port.
module dc_data_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 2,
    parameter int WPL    = 4,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WRD_W = $clog2(WPL),
    localparam int WAY_W = $clog2(WAYS),
    localparam int BE_W  = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rd_en,
    input  logic [SET_W-1:0]            rd_set,
    input  logic [WRD_W-1:0]            rd_word,
    output logic [WAYS-1:0][DATA_W-1:0] rd_q,
    input  logic                        we,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [WRD_W-1:0]            wr_word,
    input  logic [BE_W-1:0]             wr_be,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [WAY_W-1:0]            wb_way,
    input  logic [SET_W-1:0]            wb_set,
    input  logic [WRD_W-1:0]            wb_word,
    output logic [DATA_W-1:0]           wb_data
);
    localparam int DEPTH = SETS * WPL;
    localparam int IDX_W = SET_W + WRD_W;

    logic [IDX_W-1:0] rd_idx, wr_idx, wb_idx;
    logic [WAYS-1:0][DATA_W-1:0] wb_vec;

    assign rd_idx = {rd_set, rd_word};
    assign wr_idx = {wr_set, wr_word};
    assign wb_idx = {wb_set, wb_word};
    assign wb_data = wb_vec[wb_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem [DEPTH];
        logic [DATA_W-1:0] merged;
        logic [DATA_W-1:0] q;
        logic              hit_wr;

        assign hit_wr    = we && (wr_way == WAY_W'(w));
        assign rd_q[w]   = q;
        assign wb_vec[w] = mem[wb_idx];

        // Merge the enabled bytes of the write into the stored word.
        always_comb begin
            merged = mem[wr_idx];
            for (int b = 0; b < BE_W; b++)
                if (wr_be[b]) merged[8*b +: 8] = wr_data[8*b +: 8];
        end

        // Array write port.
        always_ff @(posedge clk) begin
            if (hit_wr) mem[wr_idx] <= merged;
        end

        // Stage-one read register, forwarding a write to the same word.
        always_ff @(posedge clk) begin
            if (rd_en) q <= (hit_wr && wr_idx == rd_idx) ? merged : mem[rd_idx];
        end
    end
endmodule

// File: rtl/dc_tag_store.sv
// Tag store: tag, valid and dirty per way and set, plus one LRU bit per set.
// Registered tag/valid read for stage one; combinational victim choice for
// the set in stage two. Assumes two ways. Tags change only while the cache
// is stalled, so the registered read needs no forwarding.
module dc_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 2,
    parameter int TAG_W = 22,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0][TAG_W-1:0] tag_q,
    output logic [WAYS-1:0]            valid_q,
    input  logic [SET_W-1:0]           vic_set,
    output logic [WAY_W-1:0]           vic_way,
    output logic                       vic_wb,
    output logic [TAG_W-1:0]           vic_tag,
    input  logic                       fill_en,
    input  logic [WAY_W-1:0]           fill_way,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic                       dirty_en,
    input  logic [WAY_W-1:0]           dirty_way,
    input  logic                       touch_en,
    input  logic [WAY_W-1:0]           touch_way,
    input  logic [SET_W-1:0]           upd_set
);
    logic [TAG_W-1:0] tag_mem [WAYS][SETS];
    logic             valid_r [WAYS][SETS];
    logic             dirty_r [WAYS][SETS];
    logic [WAY_W-1:0] lru_r   [SETS];
    logic             found;

    // Victim: first invalid way, else the least recently used way.
    always_comb begin
        vic_way = lru_r[vic_set];
        found   = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_r[w][vic_set]) begin
                vic_way = WAY_W'(w);
                found   = 1'b1;
            end
        end
        vic_wb  = valid_r[vic_way][vic_set] && dirty_r[vic_way][vic_set];
        vic_tag = tag_mem[vic_way][vic_set];
    end

    // Metadata updates: reset, refill, dirty marking and LRU touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                lru_r[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    valid_r[w][s] <= 1'b0;
                    dirty_r[w][s] <= 1'b0;
                end
            end
        end else begin
            if (fill_en) begin
                tag_mem[fill_way][upd_set] <= fill_tag;
                valid_r[fill_way][upd_set] <= 1'b1;
                dirty_r[fill_way][upd_set] <= 1'b0;
            end
            if (dirty_en) dirty_r[dirty_way][upd_set] <= 1'b1;
            if (touch_en) lru_r[upd_set] <= ~touch_way;
        end
    end

    // Stage-one registered read of tags and valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (rd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                tag_q[w]   <= tag_mem[w][rd_set];
                valid_q[w] <= valid_r[w][rd_set];
            end
        end
    end

    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> !dirty_r[$past(fill_way)][$past(upd_set)]); // R7
endmodule

// File: rtl/dc_miss_fsm.sv
// Miss sequencer: write-back of a dirty victim, one line read, refill
// counting and a replay cycle that reloads the stage-one read registers.
// Assumes memory accepts every request and returns refill words in order.
module dc_miss_fsm
    import dc_pkg::*;
#(
    parameter int WPL_P = 4,
    localparam int BEAT_W = $clog2(WPL_P)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss,
    input  logic [WAY_W-1:0]  vic_way_in,
    input  logic              vic_wb,
    input  logic              mem_rsp_valid,
    output miss_state_t       state,
    output logic [BEAT_W-1:0] beat,
    output logic [WAY_W-1:0]  vic_way_q
);
    logic last;
    assign last = (beat == BEAT_W'(WPL_P - 1));

    // State, beat counter and latched victim way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= MS_IDLE;
            beat      <= '0;
            vic_way_q <= '0;
        end else begin
            unique case (state)
                MS_IDLE: if (miss) begin
                    vic_way_q <= vic_way_in;
                    beat      <= '0;
                    state     <= vic_wb ? MS_WBACK : MS_REQ;
                end
                MS_WBACK: begin
                    beat <= beat + 1'b1;
                    if (last) state <= MS_REQ;
                end
                MS_REQ: begin
                    beat  <= '0;
                    state <= MS_FILL;
                end
                MS_FILL: if (mem_rsp_valid) begin
                    beat <= beat + 1'b1;
                    if (last) state <= MS_REPLAY;
                end
                default: state <= MS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dc_two_stage.sv
// Two-way write-back, write-allocate L1 data cache over two stages.
// Stage one: index bits start tag and data reads. Stage two: tag compare
// selects the way, loads return, stores write on hit. A miss stalls,
// evicts, refills and replays. The requester holds its request while stalled.
module dc_two_stage
    import dc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_be,
    output logic        stall,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        mem_req_valid,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata
);
    localparam int LOW_W = WORD_OFS + BYTE_OFS;

    logic                s2_valid, s2_write;
    logic [TAG_W-1:0]    s2_tag;
    logic [SET_W-1:0]    s2_set;
    logic [WORD_OFS-1:0] s2_word;
    logic [DATA_W-1:0]   s2_wdata;
    logic [BYTES_PW-1:0] s2_be;

    logic [WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [WAYS-1:0]             valid_q, hit_vec;
    logic [WAYS-1:0][DATA_W-1:0] data_q;
    logic [WAY_W-1:0]            hit_way, vic_way, vic_way_q;
    logic [TAG_W-1:0]            vic_tag;
    logic                        vic_wb, hit, idle, miss, done, replay;
    logic                        rd_en, store_we, fill_we, fill_last;
    logic [SET_W-1:0]            rd_set;
    logic [WORD_OFS-1:0]         rd_word, beat;
    logic [DATA_W-1:0]           wb_data;
    miss_state_t                 state;

    // Stage-two tag compare and hit-way encode.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[w] && (tag_q[w] == s2_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit       = |hit_vec;
    assign idle      = (state == MS_IDLE);
    assign replay    = (state == MS_REPLAY);
    assign miss      = idle && s2_valid && !hit;
    assign done      = idle && s2_valid && hit;
    assign stall     = !idle || miss;
    assign rsp_valid = done;
    assign rsp_rdata = data_q[hit_way];

    assign rd_en     = !stall || replay;
    assign rd_set    = replay ? s2_set  : req_addr[LOW_W +: SET_W];
    assign rd_word   = replay ? s2_word : req_addr[BYTE_OFS +: WORD_OFS];
    assign store_we  = done && s2_write;
    assign fill_we   = (state == MS_FILL) && mem_rsp_valid;
    assign fill_last = fill_we && (beat == WORD_OFS'(WPL - 1));

    assign mem_req_valid = (state == MS_WBACK) || (state == MS_REQ);
    assign mem_req_write = (state == MS_WBACK);
    assign mem_req_wdata = wb_data;
    assign mem_req_addr  = mem_req_write ? {vic_tag, s2_set, beat, {BYTE_OFS{1'b0}}}
                                         : {s2_tag, s2_set, {LOW_W{1'b0}}};

    // Stage-one to stage-two request register; held while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
        end else if (!stall) begin
            s2_valid <= req_valid;
            s2_write <= req_write;
            s2_tag   <= req_addr[ADDR_W-1 -: TAG_W];
            s2_set   <= req_addr[LOW_W +: SET_W];
            s2_word  <= req_addr[BYTE_OFS +: WORD_OFS];
            s2_wdata <= req_wdata;
            s2_be    <= req_be;
        end
    end

    dc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_set(rd_set), .tag_q(tag_q), .valid_q(valid_q),
        .vic_set(s2_set), .vic_way(vic_way), .vic_wb(vic_wb), .vic_tag(vic_tag),
        .fill_en(fill_last), .fill_way(vic_way_q), .fill_tag(s2_tag),
        .dirty_en(store_we), .dirty_way(hit_way),
        .touch_en(done), .touch_way(hit_way), .upd_set(s2_set)
    );

    dc_data_store #(.SETS(SETS), .WAYS(WAYS), .WPL(WPL), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_en(rd_en), .rd_set(rd_set), .rd_word(rd_word), .rd_q(data_q),
        .we(store_we || fill_we),
        .wr_way(fill_we ? vic_way_q : hit_way),
        .wr_set(s2_set),
        .wr_word(fill_we ? beat : s2_word),
        .wr_be(fill_we ? {BYTES_PW{1'b1}} : s2_be),
        .wr_data(fill_we ? mem_rsp_rdata : s2_wdata),
        .wb_way(vic_way_q), .wb_set(s2_set), .wb_word(beat), .wb_data(wb_data)
    );

    dc_miss_fsm #(.WPL_P(WPL)) u_miss (
        .clk(clk), .rst_n(rst_n), .miss(miss),
        .vic_way_in(vic_way), .vic_wb(vic_wb), .mem_rsp_valid(mem_rsp_valid),
        .state(state), .beat(beat), .vic_way_q(vic_way_q)
    );

    AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[BYTE_OFS-1:0] == '0); // R2
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> s2_valid && $stable(s2_tag) && $stable(s2_set) && $stable(s2_word)); // R5
    AST_SINGLE_LINE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write |=> !mem_req_valid); // R5
    AST_WB_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |=> mem_req_valid); // R7
    AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R8
    AST_RSP_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !stall && !mem_req_valid); // R10
endmodule

// File: tb/dc_two_stage_tb.sv
// Scoreboard bench: the access task predicts each result from a reference
// memory and queues it; a monitor pops and compares on every rsp_valid.
module dc_two_stage_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        stall, rsp_valid, mem_req_valid, mem_req_write;
    logic [31:0] rsp_rdata, mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int errors = 0, checks = 0, wr_beats = 0, rd_reqs = 0, wr_at_rd = 0, stall_cyc = 0;
    bit finished = 0;
    logic [31:0] last_rd_addr;
    logic [31:0] wlog [$];
    logic [31:0] mm  [int unsigned];
    logic [31:0] rfm [int unsigned];
    bit          q_wr  [$];
    logic [31:0] q_dat [$];

    always #5 clk = ~clk;

    dc_two_stage u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    function automatic logic [31:0] init_val(int unsigned wa);
        return (wa * 32'h9E3779B1) ^ 32'h1234_5678;
    endfunction
    function automatic logic [31:0] mm_rd(int unsigned wa);
        return mm.exists(wa) ? mm[wa] : init_val(wa);
    endfunction
    function automatic logic [31:0] rf_rd(int unsigned wa);
        return rfm.exists(wa) ? rfm[wa] : init_val(wa);
    endfunction
    function automatic logic [31:0] mk(int tg, int st, int wd);
        return {22'(tg), 6'(st), 2'(wd), 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: predict and queue the result, then present the request until taken.
    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] cur;
        cur = rf_rd(a >> 2);
        if (wr) begin
            for (int b = 0; b < 4; b++) if (be[b]) cur[8*b +: 8] = d[8*b +: 8];
            rfm[a >> 2] = cur;
        end
        q_wr.push_back(wr);
        q_dat.push_back(cur);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (stall) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic drain();
        while (q_wr.size() != 0 || stall) @(negedge clk);
        #1;
    endtask

    // Monitor: compare each completion with the head of the scoreboard (R10).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_wr.size() == 0) chk(0, "R10 unexpected response", rsp_rdata, 0);
            else begin
                bit wr; logic [31:0] e;
                wr = q_wr.pop_front();
                e  = q_dat.pop_front();
                if (!wr) chk(rsp_rdata == e, "R10 load data in order", rsp_rdata, e);
            end
        end
        if (rst_n && stall) stall_cyc++;
    end

    // Behavioural memory: takes writes, answers a line read every other cycle.
    int unsigned rd_base; int rd_left = 0, rd_idx = 0; bit gap = 0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rd_left > 0) begin
            if (gap) gap = 0;
            else begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mm_rd(rd_base + rd_idx);
                rd_idx++; rd_left--; gap = 1;
            end
        end
        if (rst_n && mem_req_valid) begin
            if (mem_req_write) begin
                mm[mem_req_addr >> 2] = mem_req_wdata;
                wr_beats++;
                wlog.push_back(mem_req_addr);
            end else begin
                rd_base = mem_req_addr >> 2; rd_left = 4; rd_idx = 0; gap = 1;
                rd_reqs++; wr_at_rd = wr_beats; last_rd_addr = mem_req_addr;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int rd0, wr0, st0;
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R1: quiet after reset
        chk(!stall && !rsp_valid && !mem_req_valid, "R1 reset outputs",
            {29'b0, stall, rsp_valid, mem_req_valid}, 0);

        // R5: cold load miss, one line read at line base, clean victim
        rd0 = rd_reqs; wr0 = wr_beats;
        access(0, mk(1, 5, 2), 0, 0);
        go_idle();
        chk(stall == 1'b1, "R5 stall on miss", 32'(stall), 1);
        drain();
        chk(rd_reqs - rd0 == 1, "R5 one line read", rd_reqs - rd0, 1);
        chk(last_rd_addr == mk(1, 5, 0), "R5 line base address", last_rd_addr, mk(1, 5, 0));
        chk(wr_beats == wr0, "R7 no write-back for invalid victim", wr_beats - wr0, 0);

        // R2: hit latency of one cycle, no stall
        rd0 = rd_reqs;
        access(0, mk(1, 5, 2), 0, 0);
        go_idle();
        chk(rsp_valid && !stall, "R2 hit response next cycle", 32'(rsp_valid), 1);
        drain();
        chk(rd_reqs == rd0, "R2 hit makes no memory read", rd_reqs - rd0, 0);

        // R3/R4/R9: store hit with sparse enables, then back-to-back loads
        st0 = stall_cyc; wr0 = wr_beats;
        access(1, mk(1, 5, 2), 32'hDEAD_BEEF, 4'b0101);
        access(0, mk(1, 5, 2), 0, 0);
        for (int i = 0; i < 4; i++) access(0, mk(1, 5, i), 0, 0);
        go_idle(); drain();
        chk(stall_cyc == st0, "R3 back-to-back hits never stall", stall_cyc - st0, 0);
        chk(wr_beats == wr0, "R9 store hit writes no memory", wr_beats - wr0, 0);
        chk(mm_rd(mk(1, 5, 2) >> 2) == init_val(mk(1, 5, 2) >> 2), "R9 memory unchanged",
            mm_rd(mk(1, 5, 2) >> 2), init_val(mk(1, 5, 2) >> 2));
        chk(rf_rd(mk(1, 5, 2) >> 2) != init_val(mk(1, 5, 2) >> 2), "R4 enabled bytes predicted",
            rf_rd(mk(1, 5, 2) >> 2), 0);

        // R6: store miss allocates way 1 and merges
        rd0 = rd_reqs;
        access(1, mk(2, 5, 1), 32'h0BAD_F00D, 4'b1110);
        access(0, mk(2, 5, 1), 0, 0);
        access(0, mk(2, 5, 3), 0, 0);
        go_idle(); drain();
        chk(rd_reqs - rd0 == 1, "R6 write-allocate fetches line", rd_reqs - rd0, 1);

        // R8/R7: touch A, then C evicts dirty B with ordered write-back
        access(0, mk(1, 5, 0), 0, 0);
        go_idle(); drain();
        wr0 = wr_beats; rd0 = rd_reqs; wlog.delete();
        access(0, mk(3, 5, 0), 0, 0);
        go_idle(); drain();
        chk(wr_beats - wr0 == 4, "R7 dirty victim four beats", wr_beats - wr0, 4);
        chk(wr_at_rd - wr0 == 4, "R7 write-back before line read", wr_at_rd - wr0, 4);
        for (int i = 0; i < 4 && i < wlog.size(); i++)
            chk(wlog[i] == mk(2, 5, i), "R7 write-back address order", wlog[i], mk(2, 5, i));
        chk(mm_rd(mk(2, 5, 1) >> 2) == rf_rd(mk(2, 5, 1) >> 2), "R7 written-back data",
            mm_rd(mk(2, 5, 1) >> 2), rf_rd(mk(2, 5, 1) >> 2));
        rd0 = rd_reqs;
        access(0, mk(1, 5, 2), 0, 0);
        go_idle(); drain();
        chk(rd_reqs == rd0, "R8 recently used line kept", rd_reqs - rd0, 0);
        wr0 = wr_beats;
        access(0, mk(2, 5, 1), 0, 0);
        go_idle(); drain();
        chk(rd_reqs - rd0 == 1, "R8 evicted line misses", rd_reqs - rd0, 1);
        chk(wr_beats == wr0, "R7 clean victim not written", wr_beats - wr0, 0);

        // R10: pseudo-random mix across two sets and four tags
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[0], mk(1 + lfsr[3:2], lfsr[4] ? 9 : 5, lfsr[6:5]),
                   {lfsr, ~lfsr}, lfsr[11:8]);
        end
        go_idle(); drain();
        chk(q_wr.size() == 0, "R10 every access answered", q_wr.size(), 0);
        finish_run();
    end
endmodule